// File: doc/BRIEF.md
# One-Shot Retriggerable Pulse Timer

This block is a single timer channel that produces exactly one output pulse each time software starts it. An up-counter advances on each qualified tick while the channel runs. The output is high whenever the counter is at or above a width threshold, so each run gives one pulse. When the counter has reached the period threshold, the next tick returns it to zero and the channel stops by itself. To get another pulse, software must start the channel again.

The period and width thresholds are each held in a software-written register with a shadow copy, and the comparators only use the shadow copy. A shadow copy is reloaded when the channel starts. It is also reloaded at once when its register is written while the channel is stopped. Software may load the counter at any time. Before a start, the loaded value sets the delay before the rising edge, which is the width minus the start value. While the channel runs, a counter load moves whichever edge is still to come. Loading the period value ends the run on the next tick.

The control is a two-state machine: ST_IDLE (stopped) and ST_RUN (counting). From ST_IDLE, the START transition goes to ST_RUN on a run request. From ST_RUN there are four transitions. EXPIRE goes back to ST_IDLE on the end-of-period tick. RESTART stays in ST_RUN when a run request lands on that same tick. ABORT goes to ST_IDLE on a software stop request. HOLD stays in ST_RUN otherwise, and covers a run request that arrives while the channel is already counting.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the counter is 0, the channel is stopped, the cycle-start event is low and the pulse output is low. The period shadow resets to 0 and the width shadow resets to all ones (0xFFFF).
- R2: A run request while stopped starts the channel on the next edge and loads both shadows from their registers. If a register is written in that same cycle, its new value is loaded. The cycle-start output is high for exactly the one cycle after any shadow reload caused by a start.
- R3: While running, the counter increases by one on each cycle with the tick input high, unless it is at the end of period or is being written. With tick low it holds its value.
- R4: While running, a tick with the counter equal to the period shadow (and no counter write) clears the counter to 0 and stops the channel.
- R5: The pulse output is high exactly when the counter is greater than or equal to the width shadow. From a start at counter 0, one run therefore gives a pulse of period−width+1 ticks after a delay of width ticks.
- R6: Writes to the period or width register while running do not change the shadows until the next start.
- R7: Writes to the period or width register while stopped update the matching shadow on the next edge, and do not raise the cycle-start event.
- R8: A counter write while running replaces the count. A value below the width delays a rising edge that has not yet happened. A value at or above the width moves the falling edge of a pulse already in progress.
- R9: Writing the counter with the period value while running ends the pulse on the next tick: the counter becomes 0 and the channel stops.
- R10: A run request in the same cycle as the end-of-period tick keeps the channel running. The counter goes to 0, the shadows reload, and the cycle-start event is raised.
- R11: A stop request without a run request stops counting and leaves the counter and pulse level unchanged. A run request takes priority over a stop request given in the same cycle.
- R12: A counter write in a cycle where the tick is high takes priority over counting and the end-of-period clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for the counter |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| per_wr | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period register write value |
| wid_wr | input | 1 | Width register write strobe |
| wid_wdata | input | 16 | Width register write value |
| run_set | input | 1 | Software run request |
| run_clr | input | 1 | Software stop request |
| pulse_o | output | 1 | Pulse output |
| running_o | output | 1 | Channel run status |
| cycle_start_o | output | 1 | One-cycle event after a start reloads the shadows |
| count_o | output | 16 | Current counter value |

## Verification
The first runs use a free-running tick with different period and width pairs, including a width of zero and a width above the period. Comparing pulse length and delay across these runs tells the edge-compare rule apart from off-by-one variants. Gated-tick runs check that the counter advances only on ticks. Counter writes made before and during a run, landing on both sides of the width and exactly on the period, check that the delay, the edge moves and the abort all follow from the single compare. Requests that collide in one cycle check the START, RESTART, ABORT and HOLD priorities: run against end-of-period, run against stop, and write against tick.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ost_state_e;

endpackage

// File: rtl/ost_ctrl.sv
module ost_ctrl
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_set,
    input  logic run_clr,
    input  logic end_hit,
    output logic running,
    output logic start,
    output logic cycle_start
);

    ost_state_e state_q;
    ost_state_e state_d;
    logic       start_d;
    logic       cs_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_set) begin            // START
                    state_d = ST_RUN;
                    start_d = 1'b1;
                end
            end
            ST_RUN: begin
                if (run_set && end_hit) begin // RESTART
                    state_d = ST_RUN;
                    start_d = 1'b1;
                end else if (run_set) begin   // HOLD
                    state_d = ST_RUN;
                end else if (run_clr) begin   // ABORT
                    state_d = ST_IDLE;
                end else if (end_hit) begin   // EXPIRE
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cs_q    <= start_d;
        end
    end

    // outputs
    always_comb begin
        running     = (state_q == ST_RUN);
        start       = start_d;
        cycle_start = cs_q;
    end

endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         running,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] per_sh,
    output logic [W-1:0] count,
    output logic         end_hit
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_comb begin
        end_hit = running && tick && !wr && (cnt_q == per_sh);
        count   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr) begin
            cnt_q <= wdata;
        end else if (end_hit) begin
            cnt_q <= '0;
        end else if (running && tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/ost_shadow.sv
module ost_shadow #(
    parameter int          W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         running,
    input  logic         start,
    output logic [W-1:0] sh
);

    logic [W-1:0] reg_q;
    logic [W-1:0] sh_q;
    logic [W-1:0] src;

    always_comb begin
        src = wr ? wdata : reg_q;
        sh  = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RST;
            sh_q  <= RST;
        end else begin
            if (wr) begin
                reg_q <= wdata;
            end
            if (start || (wr && !running)) begin
                sh_q <= src;
            end
        end
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         per_wr,
    input  logic [W-1:0] per_wdata,
    input  logic         wid_wr,
    input  logic [W-1:0] wid_wdata,
    input  logic         run_set,
    input  logic         run_clr,
    output logic         pulse_o,
    output logic         running_o,
    output logic         cycle_start_o,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] PER_RST = '0;
    localparam logic [W-1:0] WID_RST = '1;

    logic         running;
    logic         start;
    logic         end_hit;
    logic         cycle_start;
    logic [W-1:0] count;
    logic [W-1:0] per_sh;
    logic [W-1:0] wid_sh;

    ost_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_set     (run_set),
        .run_clr     (run_clr),
        .end_hit     (end_hit),
        .running     (running),
        .start       (start),
        .cycle_start (cycle_start)
    );

    ost_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .running (running),
        .wr      (cnt_wr),
        .wdata   (cnt_wdata),
        .per_sh  (per_sh),
        .count   (count),
        .end_hit (end_hit)
    );

    ost_shadow #(.W(W), .RST(PER_RST)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (per_wr),
        .wdata   (per_wdata),
        .running (running),
        .start   (start),
        .sh      (per_sh)
    );

    ost_shadow #(.W(W), .RST(WID_RST)) u_wid (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wid_wr),
        .wdata   (wid_wdata),
        .running (running),
        .start   (start),
        .sh      (wid_sh)
    );

    always_comb begin
        pulse_o       = (count >= wid_sh);
        running_o     = running;
        cycle_start_o = cycle_start;
        count_o       = count;
    end

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         cnt_wr,
    input logic         wid_wr,
    input logic         run_set,
    input logic         run_clr,
    input logic         pulse_o,
    input logic         running_o,
    input logic         cycle_start_o,
    input logic [W-1:0] count_o,
    input logic [W-1:0] per_sh,
    input logic [W-1:0] wid_sh
);

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && run_set) |=> (running_o && cycle_start_o));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick && !cnt_wr && (count_o != per_sh))
            |=> (count_o == W'($past(count_o) + 1'b1)));

    // R4
    period_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick && !cnt_wr && !run_set && (count_o == per_sh))
            |=> (!running_o && (count_o == '0)));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !run_set) |=> ($stable(per_sh) && $stable(wid_sh)));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && run_set && tick && !cnt_wr && (count_o == per_sh))
            |=> (running_o && cycle_start_o && (count_o == '0)));

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !run_set && !cnt_wr && !wid_wr) |=> $stable(pulse_o));

    // R2
    event_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> running_o);

endmodule

bind oneshot_timer oneshot_timer_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .cnt_wr        (cnt_wr),
    .wid_wr        (wid_wr),
    .run_set       (run_set),
    .run_clr       (run_clr),
    .pulse_o       (pulse_o),
    .running_o     (running_o),
    .cycle_start_o (cycle_start_o),
    .count_o       (count_o),
    .per_sh        (per_sh),
    .wid_sh        (wid_sh)
);

// File: tb/oneshot_timer_tb.sv
module oneshot_timer_tb;

    localparam int W = 16;

    typedef struct {
        logic         pulse;
        logic         run;
        logic         cs;
        logic [W-1:0] cnt;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         cnt_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic         per_wr = 1'b0;
    logic [W-1:0] per_wdata = '0;
    logic         wid_wr = 1'b0;
    logic [W-1:0] wid_wdata = '0;
    logic         run_set = 1'b0;
    logic         run_clr = 1'b0;
    logic         pulse_o;
    logic         running_o;
    logic         cycle_start_o;
    logic [W-1:0] count_o;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    // pending stimulus for the next step
    logic         p_tick = 1'b1;
    logic         p_cw = 1'b0, p_pw = 1'b0, p_ww = 1'b0, p_rs = 1'b0, p_rc = 1'b0;
    logic [W-1:0] p_cwd = '0, p_pwd = '0, p_wwd = '0;

    // bench model of the requirement rules
    logic [W-1:0] m_cnt = '0, m_per = '0, m_wid = '1, m_psh = '0, m_wsh = '1;
    logic         m_run = 1'b0;

    always #2 clk = ~clk;

    oneshot_timer #(.W(W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .cnt_wr        (cnt_wr),
        .cnt_wdata     (cnt_wdata),
        .per_wr        (per_wr),
        .per_wdata     (per_wdata),
        .wid_wr        (wid_wr),
        .wid_wdata     (wid_wdata),
        .run_set       (run_set),
        .run_clr       (run_clr),
        .pulse_o       (pulse_o),
        .running_o     (running_o),
        .cycle_start_o (cycle_start_o),
        .count_o       (count_o)
    );

    task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {pulse,run,cs,cnt}=%h expected %h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected result
    task automatic go(input string tag);
        logic         endh, st;
        logic [W-1:0] ncnt, npsh, nwsh;
        logic         nrun;
        exp_t         e;
        @(negedge clk);
        tick = p_tick; cnt_wr = p_cw; cnt_wdata = p_cwd;
        per_wr = p_pw; per_wdata = p_pwd; wid_wr = p_ww; wid_wdata = p_wwd;
        run_set = p_rs; run_clr = p_rc;
        endh = m_run && p_tick && !p_cw && (m_cnt == m_psh);          // R4, R12
        st   = (!m_run && p_rs) || (m_run && p_rs && endh);           // R2, R10
        npsh = st ? (p_pw ? p_pwd : m_per) : ((p_pw && !m_run) ? p_pwd : m_psh); // R6, R7
        nwsh = st ? (p_ww ? p_wwd : m_wid) : ((p_ww && !m_run) ? p_wwd : m_wsh);
        if (p_cw)               ncnt = p_cwd;                          // R8
        else if (endh)          ncnt = '0;
        else if (m_run && p_tick) ncnt = m_cnt + 1'b1;                 // R3
        else                    ncnt = m_cnt;
        nrun = p_rs ? 1'b1 : (m_run && !p_rc && !endh);                // R11
        if (p_pw) m_per = p_pwd;
        if (p_ww) m_wid = p_wwd;
        m_cnt = ncnt; m_psh = npsh; m_wsh = nwsh; m_run = nrun;
        e.pulse = (ncnt >= nwsh);                                      // R5
        e.run = nrun; e.cs = st; e.cnt = ncnt; e.tag = tag;
        q.push_back(e);
        p_cw = 1'b0; p_pw = 1'b0; p_ww = 1'b0; p_rs = 1'b0; p_rc = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) go(tag);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {pulse_o, running_o, cycle_start_o, count_o},
                      {e.pulse, e.run, e.cs, e.cnt});
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {pulse_o, running_o, cycle_start_o, count_o}, {1'b0, 1'b0, 1'b0, 16'h0000});

        // R7: write thresholds while stopped
        p_tick = 1'b1;
        p_pw = 1; p_pwd = 16'd5; p_ww = 1; p_wwd = 16'd2; go("R7");
        idle(2, "R7");
        // R2 start, R3 count, R5 pulse, R4 end
        p_rs = 1; go("R2");
        idle(8, "R5");
        // R3 gated tick
        p_rs = 1; go("R2");
        p_tick = 1'b0; idle(3, "R3");
        p_tick = 1'b1; idle(6, "R4");
        // R5 width 0 and width above period
        p_ww = 1; p_wwd = 16'd0; go("R5");
        p_rs = 1; go("R5");
        idle(7, "R5");
        p_ww = 1; p_wwd = 16'd9; go("R5");
        p_rs = 1; go("R5");
        idle(7, "R5");
        // R6 writes while running are deferred
        p_ww = 1; p_wwd = 16'd3; go("R7");
        p_rs = 1; go("R2");
        p_pw = 1; p_pwd = 16'd9; p_ww = 1; p_wwd = 16'd7; go("R6");
        idle(6, "R6");
        p_rs = 1; go("R6");
        idle(11, "R6");
        // R8 retrigger: rising edge delayed, then falling edge moved; R12 with tick
        p_pw = 1; p_pwd = 16'd10; p_ww = 1; p_wwd = 16'd5; go("R7");
        p_cw = 1; p_cwd = 16'd0; go("R8");
        p_rs = 1; go("R2");
        idle(3, "R8");
        p_cw = 1; p_cwd = 16'd1; go("R12");
        idle(5, "R8");
        p_cw = 1; p_cwd = 16'd6; go("R8");
        idle(6, "R8");
        // R9 abort by loading the period value
        p_rs = 1; go("R2");
        idle(6, "R9");
        p_cw = 1; p_cwd = 16'd10; go("R9");
        idle(3, "R9");
        // pulse delay from preloaded counter
        p_cw = 1; p_cwd = 16'd2; go("R5");
        p_rs = 1; go("R5");
        idle(10, "R5");
        // R10 run request on end-of-period tick
        p_pw = 1; p_pwd = 16'd3; p_ww = 1; p_wwd = 16'd1; go("R7");
        p_rs = 1; go("R2");
        idle(3, "R10");
        p_rs = 1; go("R10");
        idle(5, "R10");
        // R11 stop holds level; set beats clear
        p_rs = 1; go("R2");
        idle(2, "R11");
        p_rs = 1; p_rc = 1; go("R11");
        p_rc = 1; go("R11");
        idle(4, "R11");
        p_rs = 1; go("R11");
        idle(4, "R11");
        p_tick = 1'b0;
        idle(1, "R11");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule